// File: doc/BRIEF.md
# Framer Interrupt Status Controller

This block gathers the alarm and event indications of a T1 frame processor into one small register set and one interrupt line. Exactly one source, the out-of-frame condition, is a level: its status bit follows the condition, and every change of that status, in either direction, latches an indication. The other nine sources are single-cycle event pulses with no status bit. Each pulse latches its indication directly.

Indications are sticky until the host clears them by writing ones. A per-source enable mask selects which indications reach the interrupt output. The output is a registered, active-high OR of the enabled indications. A plain write/read port with a two-bit address gives the host access to status, indications and enables. The number of sources, how many of them are levels, and the data width are parameters. Level sources occupy the lowest bit positions.

Top module: `framer_irq_ctrl`

## Requirements
- R1: The status register (address 0) shows, in bit 0, the out-of-frame level as it was one clock earlier. Bits of event sources read 0 there.
- R2: A change of the out-of-frame level against its status bit, whether from 0 to 1 or from 1 to 0, sets indication bit 0 at the next clock. A level that stays constant sets nothing.
- R3: A one-cycle pulse on an event source (bits 1 to 9) sets its indication bit at the next clock. The status register is not touched.
- R4: An indication bit stays at 1 until it is cleared by the host.
- R5: A write to address 1 clears every indication bit whose write-data bit is 1. Bits written with 0 keep their value.
- R6: When a set and a host clear reach the same indication bit in the same cycle, the bit ends up 1.
- R7: `irq_o` is high in a cycle exactly when, at the previous clock, some indication bit and its enable bit (address 2) were both 1.
- R8: Address 2 reads back the last value written to it. Writes to address 0 or 3 change no register. Address 3 reads 0, and data bits above the source count read 0.
- R9: Reset clears the status, indication and enable registers and drives `irq_o` low.
- R10: Bit positions are fixed as follows. Bit 0 is out-of-frame. Bit 1 is frame start. Bit 2 is alignment move. Bit 3 is framing-bit error. Bit 4 is CRC-6 error. Bit 5 is severe framing error. Bits 6 to 9 are the four superframe data-link field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Source conditions: level for bits below NUM_LEVEL, one-cycle pulses above |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 indication, 2 enable |
| wr_data_i | input | DATA_W | Host write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational from the registers |
| irq_o | output | 1 | Registered, active-high interrupt |

## Verification
The bench builds the block with its default parameters: ten sources, one of them a level, and a 16-bit data word. With these values every indication and enable bit can be reached, and so can the unused upper data bits 10 to 15, which must read zero. A directed sequence covers both edges of the level source and a clear while that level is held. It also covers the collision of a set and a clear, ignored writes to the status and spare addresses, and the one-cycle lag of the interrupt behind its enable. Random sparse pulses, level toggles and host writes at all four addresses then exercise arbitrary mixes of set, clear and mask.

// File: rtl/framer_irq_pkg.sv
package framer_irq_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_STAT  = 2'd0,
      REG_IND   = 2'd1,
      REG_EN    = 2'd2,
      REG_SPARE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/fic_src_cell.sv
module fic_src_cell #(
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic clr_i,
   output logic stat_o,
   output logic ind_o
);

   logic set_w;
   logic ind_q;

   generate
      if (IS_LEVEL) begin : g_level
         logic stat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q <= 1'b0;
            else        stat_q <= src_i;
         end
         // any difference between the live level and its stored status is an edge
         assign set_w  = src_i ^ stat_q;
         assign stat_o = stat_q;
      end else begin : g_event
         assign set_w  = src_i;
         assign stat_o = 1'b0;
      end
   endgenerate

   // a new event outranks a host clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ind_q <= 1'b0;
      else        ind_q <= set_w | (ind_q & ~clr_i);
   end

   assign ind_o = ind_q;

endmodule

// File: rtl/fic_host_port.sv
module fic_host_port
   import framer_irq_pkg::*;
#(
   parameter int NUM_SRC = 10,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [NUM_SRC-1:0] stat_i,
   input  logic [NUM_SRC-1:0] ind_i,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [NUM_SRC-1:0] en_o,
   output logic [DATA_W-1:0]  rd_data_o
);

   reg_sel_e          sel;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] wr_bits;

   assign sel     = reg_sel_e'(addr_i);
   assign wr_bits = wr_data_i[NUM_SRC-1:0];

   generate
      if (DATA_W > NUM_SRC) begin : g_hi
         logic unused_wr_hi;
         assign unused_wr_hi = ^wr_data_i[DATA_W-1:NUM_SRC];
      end
   endgenerate

   assign clr_o = (wr_en_i && (sel == REG_IND)) ? wr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           en_q <= '0;
      else if (wr_en_i && (sel == REG_EN))  en_q <= wr_bits;
   end

   assign en_o = en_q;

   always_comb begin
      rd_data_o = '0;
      unique case (sel)
         REG_STAT:  rd_data_o[NUM_SRC-1:0] = stat_i;
         REG_IND:   rd_data_o[NUM_SRC-1:0] = ind_i;
         REG_EN:    rd_data_o[NUM_SRC-1:0] = en_q;
         REG_SPARE: rd_data_o = '0;
         default:   rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/fic_irq_gen.sv
module fic_irq_gen #(
   parameter int NUM_SRC = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] ind_i,
   input  logic [NUM_SRC-1:0] en_i,
   output logic               irq_o
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(ind_i & en_i);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/framer_irq_ctrl.sv
module framer_irq_ctrl
   import framer_irq_pkg::*;
#(
   parameter int NUM_SRC   = 10,
   parameter int NUM_LEVEL = 1,
   parameter int DATA_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   output logic [DATA_W-1:0]  rd_data_o,
   output logic               irq_o
);

   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("framer_irq_ctrl: NUM_SRC must be at least 1");
      end
      if (NUM_SRC > DATA_W) begin : g_bad_width
         $error("framer_irq_ctrl: DATA_W must hold NUM_SRC bits");
      end
      if (NUM_LEVEL < 0 || NUM_LEVEL > NUM_SRC) begin : g_bad_level
         $error("framer_irq_ctrl: NUM_LEVEL out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] stat_vec;
   logic [NUM_SRC-1:0] ind_vec;
   logic [NUM_SRC-1:0] en_vec;
   logic [NUM_SRC-1:0] clr_vec;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         fic_src_cell #(
            .IS_LEVEL(k < NUM_LEVEL)
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[k]),
            .clr_i  (clr_vec[k]),
            .stat_o (stat_vec[k]),
            .ind_o  (ind_vec[k])
         );
      end
   endgenerate

   fic_host_port #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W)
   ) u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .addr_i    (addr_i),
      .wr_data_i (wr_data_i),
      .stat_i    (stat_vec),
      .ind_i     (ind_vec),
      .clr_o     (clr_vec),
      .en_o      (en_vec),
      .rd_data_o (rd_data_o)
   );

   fic_irq_gen #(
      .NUM_SRC (NUM_SRC)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ind_i (ind_vec),
      .en_i  (en_vec),
      .irq_o (irq_o)
   );

endmodule

// File: rtl/fic_chk.sv
module fic_chk #(
   parameter int NUM_SRC   = 10,
   parameter int NUM_LEVEL = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic               wr_en_i,
   input logic [1:0]         addr_i,
   input logic [NUM_SRC-1:0] wdata,
   input logic [NUM_SRC-1:0] stat_vec,
   input logic [NUM_SRC-1:0] ind_vec,
   input logic [NUM_SRC-1:0] en_vec,
   input logic               irq_o
);

   logic [NUM_SRC-1:0] set_seen;
   logic               clr_wr;

   assign clr_wr = wr_en_i && (addr_i == 2'd1);

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
         if (k < NUM_LEVEL) begin : g_lvl
            assign set_seen[k] = src_i[k] != stat_vec[k];

            // R1
            stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> stat_vec[k] == $past(src_i[k]));

            // R2
            lvl_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (src_i[k] != stat_vec[k]) |=> ind_vec[k]);
         end else begin : g_evt
            assign set_seen[k] = src_i[k];

            // R3
            evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
               src_i[k] |=> ind_vec[k]);
         end

         // R4
         sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ind_vec[k] && !(clr_wr && wdata[k])) |=> ind_vec[k]);

         // R5
         w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && wdata[k] && !set_seen[k]) |=> !ind_vec[k]);

         // R6
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && wdata[k] && set_seen[k]) |=> ind_vec[k]);
      end
   endgenerate

   // R7
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_o == $past(|(ind_vec & en_vec)));

   // R8
   en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && addr_i == 2'd2) |=> $stable(en_vec));

endmodule

bind framer_irq_ctrl fic_chk #(
   .NUM_SRC   (NUM_SRC),
   .NUM_LEVEL (NUM_LEVEL)
) u_fic_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_i    (src_i),
   .wr_en_i  (wr_en_i),
   .addr_i   (addr_i),
   .wdata    (wr_data_i[NUM_SRC-1:0]),
   .stat_vec (stat_vec),
   .ind_vec  (ind_vec),
   .en_vec   (en_vec),
   .irq_o    (irq_o)
);

// File: tb/tb_framer_irq_ctrl.sv
`timescale 1ns/1ps
module tb_framer_irq_ctrl;

   localparam int NS = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_i = '0;
   logic          wr_en_i = 1'b0;
   logic [1:0]    addr_i = 2'd0;
   logic [DW-1:0] wr_data_i = '0;
   logic [DW-1:0] rd_data_o;
   logic          irq_o;

   int n_run  = 0;
   int n_fail = 0;

   logic [NS-1:0] m_stat = '0;
   logic [NS-1:0] m_ind  = '0;
   logic [NS-1:0] m_en   = '0;
   logic          m_irq  = 1'b0;

   always #4 clk = ~clk;

   framer_irq_ctrl #(.NUM_SRC(NS), .NUM_LEVEL(1), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   function automatic logic [DW-1:0] exp_rd(input logic [1:0] a);
      logic [DW-1:0] v;
      v = '0;
      case (a)
         2'd0: v[NS-1:0] = m_stat;
         2'd1: v[NS-1:0] = m_ind;
         2'd2: v[NS-1:0] = m_en;
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // model update from the requirements, using pre-edge state
   task automatic model_edge(input logic [NS-1:0] src, input logic we,
                             input logic [1:0] a, input logic [DW-1:0] wd);
      logic [NS-1:0] set_v, clr_v;
      set_v    = src;
      set_v[0] = src[0] ^ m_stat[0];
      clr_v    = (we && a == 2'd1) ? wd[NS-1:0] : '0;
      m_irq    = |(m_ind & m_en);
      m_ind    = set_v | (m_ind & ~clr_v);
      if (we && a == 2'd2) m_en = wd[NS-1:0];
      m_stat   = '0;
      m_stat[0] = src[0];
   endtask

   task automatic step(input logic [NS-1:0] src, input logic we, input logic [1:0] a,
                       input logic [DW-1:0] wd, input string tag);
      src_i = src; wr_en_i = we; addr_i = a; wr_data_i = wd;
      @(posedge clk);
      model_edge(src, we, a, wd);
      @(negedge clk);
      chk(tag, rd_data_o, exp_rd(a));
      chk("R7", {{(DW-1){1'b0}}, irq_o}, {{(DW-1){1'b0}}, m_irq});
      wr_en_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic lvl;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      for (int a = 0; a < 4; a++) begin
         addr_i = 2'(a); #1;
         chk("R9", rd_data_o, '0);
      end
      chk("R9", {{(DW-1){1'b0}}, irq_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 rising edge of the level source
      step(10'h001, 1'b0, 2'd1, '0, "R2");
      chk("R2", rd_data_o, 16'h0001);
      // R5 clear while level held: no re-set
      step(10'h001, 1'b1, 2'd1, 16'h0001, "R5");
      chk("R5", rd_data_o, 16'h0000);
      // R1 status reflects level
      step(10'h001, 1'b0, 2'd0, '0, "R1");
      chk("R1", rd_data_o, 16'h0001);
      // R2 falling edge also sets
      step(10'h000, 1'b0, 2'd1, '0, "R2");
      chk("R2", rd_data_o, 16'h0001);
      step(10'h000, 1'b1, 2'd1, 16'h0001, "R5");
      // R3 event pulse sets indication, status untouched
      step(10'h010, 1'b0, 2'd1, '0, "R3");
      chk("R3", rd_data_o, 16'h0010);
      step(10'h000, 1'b0, 2'd0, '0, "R3");
      chk("R3", rd_data_o, 16'h0000);
      // R6 set and clear collide on bit 5
      step(10'h020, 1'b1, 2'd1, 16'h0020, "R6");
      chk("R6", rd_data_o, 16'h0030);
      // R5 writing zeros leaves bits; R4 they persist
      step(10'h000, 1'b1, 2'd1, 16'h0000, "R5");
      step(10'h000, 1'b0, 2'd1, '0, "R4");
      chk("R4", rd_data_o, 16'h0030);
      // R7 enable bit 5, interrupt follows one cycle later
      step(10'h000, 1'b1, 2'd2, 16'h0020, "R8");
      chk("R7", {{(DW-1){1'b0}}, irq_o}, '0);
      step(10'h000, 1'b0, 2'd2, '0, "R7");
      chk("R7", {{(DW-1){1'b0}}, irq_o}, 16'h0001);
      // R8 writes to status and spare addresses ignored
      step(10'h000, 1'b1, 2'd0, 16'hFFFF, "R8");
      step(10'h000, 1'b1, 2'd3, 16'hFFFF, "R8");
      chk("R8", rd_data_o, 16'h0000);
      step(10'h000, 1'b0, 2'd1, '0, "R8");
      chk("R8", rd_data_o, 16'h0030);
      step(10'h000, 1'b1, 2'd2, 16'hFFFF, "R8");
      chk("R8", rd_data_o, 16'h03FF);
      // R10 top field-change position
      step(10'h200, 1'b0, 2'd1, '0, "R10");
      chk("R10", rd_data_o, 16'h0230);
      // R7 clear all, interrupt drops one cycle later
      step(10'h000, 1'b1, 2'd1, 16'h03FF, "R5");
      step(10'h000, 1'b0, 2'd1, '0, "R7");
      chk("R7", {{(DW-1){1'b0}}, irq_o}, '0);

      // random mix
      lvl = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         logic [NS-1:0] s;
         logic [1:0]    a;
         if ($urandom % 8 == 0) lvl = ~lvl;
         s = ($urandom % 4 == 0) ? NS'($urandom) : '0;
         s[0] = lvl;
         a = 2'($urandom);
         step(s, 1'($urandom), a, DW'($urandom),
              a == 2'd0 ? "R1" : a == 2'd1 ? "R4" : "R8");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule